// File: doc/BRIEF.md
# Packet Conservation Scoreboard

This block is a passive end-to-end monitor placed beside a packet processing pipeline. It watches two data movers that touch one I/O port address: the input mover, which reads each arriving packet out of the port, and the output mover, which writes each finished packet back to it. From every such transfer it takes a 32-bit tag built from the first four bytes of the packet. Input tags are kept as outstanding in a small content-addressable table. Output tags retire a matching entry, in any order, so the monitor proves that no packet disappears inside the pipeline.

A second rule guards the port itself. The port raises a new-data interrupt for each arriving packet, and that packet must be read by the input mover before the next interrupt comes. An interrupt that arrives while the previous packet is still unread is flagged as an overrun. At the end of a test, a single strobe checks whether any tag is still outstanding and reports the overall outcome.

All error outputs are one-cycle pulses, registered on the clock edge that samples the offending event. The outstanding count and the "all matched" status are registered state.

Top module: `pkt_conserve_mon`

## Requirements
- R1: Only a transfer whose address equals the parameter `IO_ADDR` is considered; a read or write to any other address changes no output.
- R2: A packet's tag is little-endian over its bytes: byte k is carried on bits [8k+7:8k] of the byte bus and weighs 2^(8k), so bytes 11,22,33,44 (byte 0 first) give tag 0x44332211, and a write with the same bytes in another order does not match it.
- R3: A considered input read stores its tag and raises `outstanding` by one in the cycle after the read.
- R4: A considered output write whose tag equals an outstanding tag retires exactly one such entry, lowers `outstanding` by one in the next cycle and raises no error.
- R5: A considered output write whose tag equals no outstanding tag pulses `err_unexpected` for one cycle in the next cycle and leaves `outstanding` unchanged.
- R6: A considered input read that finds no free entry pulses `err_overflow` in the next cycle and the tag is dropped; `outstanding` never exceeds `DEPTH`.
- R7: Equal tags outstanding at once are counted separately: each one needs its own output write, and the write after the last of them is unexpected.
- R8: A port interrupt while the previous packet is still unread, with no considered input read in the same cycle, pulses `err_overrun` in the next cycle; a read in the same cycle as the interrupt consumes the previous packet and no error is raised.
- R9: When `test_end` is high, the next cycle shows `err_lost` high and `all_matched` low if any tag was outstanding, and `all_matched` high otherwise; `all_matched` then holds until the next `test_end`.
- R10: After reset `outstanding` is 0 and every error output and `all_matched` are low.
- R11: In a cycle with both a read and a write, the write is matched against the table as it stood before the cycle, and an entry it retires is free for that same cycle's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_done | input | 1 | Input mover finished a read this cycle |
| rd_addr | input | ADDR_W | Source address of that read |
| rd_bytes | input | 32 | First four bytes read, byte 0 in bits [7:0] |
| wr_issue | input | 1 | Output mover issues a write this cycle |
| wr_addr | input | ADDR_W | Destination address of that write |
| wr_bytes | input | 32 | First four bytes written, byte 0 in bits [7:0] |
| port_irq | input | 1 | New-data interrupt of the I/O port |
| test_end | input | 1 | End-of-test strobe |
| err_unexpected | output | 1 | Pulse: output tag without an outstanding match |
| err_overflow | output | 1 | Pulse: input tag dropped, table full |
| err_overrun | output | 1 | Pulse: port interrupt before previous packet was read |
| err_lost | output | 1 | Pulse: tags still outstanding at end of test |
| outstanding | output | CNT_W | Number of outstanding tags |
| all_matched | output | 1 | Last end-of-test found no outstanding tag |

## Verification
Every result of this block is due exactly one clock edge after the cycle that carries its stimulus: the error pulses, the new outstanding count and the end-of-test status all come out of registers loaded on that edge. The bench drives each event on the falling edge, lets one rising edge pass and compares all outputs a short delay later, against a reference multiset of tags and a pending-packet flag that it updates on the same step. Because each step is a single cycle, a pulse that came one cycle early or late, or stayed up a second cycle, shows as a mismatch on a neighbouring step.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   localparam int TAG_BYTES = 4;
   localparam int TAG_W     = 8 * TAG_BYTES;

   typedef logic [TAG_W-1:0] tag_t;

   // Weigh byte k by 2^(8k): little-endian assembly of the packet tag.
   function automatic tag_t pcm_tag_of(input logic [TAG_W-1:0] bus);
      tag_t acc;
      acc = '0;
      for (int k = 0; k < TAG_BYTES; k++) begin
         acc = acc + (tag_t'(bus[8*k +: 8]) << (8 * k));
      end
      return acc;
   endfunction

endpackage

// File: rtl/pcm_first_set.sv
module pcm_first_set #(
   parameter int W         = 8,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] grant
);

   if (W < 1) begin : g_bad_width
      $error("pcm_first_set: W must be at least 1");
   end

   if (LOW_FIRST) begin : g_low
      always_comb begin
         logic found;
         grant = '0;
         found = 1'b0;
         for (int i = 0; i < W; i++) begin
            if (req[i] && !found) begin
               grant[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end else begin : g_high
      always_comb begin
         logic found;
         grant = '0;
         found = 1'b0;
         for (int i = W - 1; i >= 0; i--) begin
            if (req[i] && !found) begin
               grant[i] = 1'b1;
               found    = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pcm_tag_table.sv
module pcm_tag_table
   import pcm_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_en,
   input  tag_t             ins_tag,
   input  logic             ret_en,
   input  tag_t             ret_tag,
   output logic             ret_hit,
   output logic             ins_ok,
   output logic             ins_blocked,
   output logic [DEPTH-1:0] valid_vec
);

   tag_t             tag_q [DEPTH];
   logic [DEPTH-1:0] valid_q;
   logic [DEPTH-1:0] match;
   logic [DEPTH-1:0] ret_oh;
   logic [DEPTH-1:0] keep;
   logic [DEPTH-1:0] ins_oh;
   logic             any_match;
   logic             table_full;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign match[i] = valid_q[i] && (tag_q[i] == ret_tag);
   end

   pcm_first_set #(.W(DEPTH), .LOW_FIRST(1'b1)) u_ret_pick (
      .req   (match),
      .grant (ret_oh)
   );

   assign any_match = |match;
   assign ret_hit   = ret_en && any_match;
   assign keep      = valid_q & ~(ret_hit ? ret_oh : '0);

   pcm_first_set #(.W(DEPTH), .LOW_FIRST(1'b1)) u_ins_pick (
      .req   (~keep),
      .grant (ins_oh)
   );

   assign table_full  = &keep;
   assign ins_ok      = ins_en && !table_full;
   assign ins_blocked = ins_en && table_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         valid_q <= keep | (ins_ok ? ins_oh : '0);
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_store
      always_ff @(posedge clk) begin
         if (ins_ok && ins_oh[i]) begin
            tag_q[i] <= ins_tag;
         end
      end
   end

   assign valid_vec = valid_q;

endmodule

// File: rtl/pcm_overrun_watch.sv
module pcm_overrun_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   input  logic rd_hit,
   output logic overrun
);

   logic unread_q;
   logic clash;

   // The read in this cycle consumes the older packet before the new one lands.
   assign clash = irq && unread_q && !rd_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unread_q <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         overrun <= clash;
         if (irq) begin
            unread_q <= 1'b1;
         end else if (rd_hit) begin
            unread_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pkt_conserve_mon.sv
module pkt_conserve_mon
   import pcm_pkg::*;
#(
   parameter int                DEPTH   = 8,
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] IO_ADDR = 16'h0F00,
   localparam int               CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_done,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [31:0]       rd_bytes,
   input  logic              wr_issue,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_bytes,
   input  logic              port_irq,
   input  logic              test_end,
   output logic              err_unexpected,
   output logic              err_overflow,
   output logic              err_overrun,
   output logic              err_lost,
   output logic [CNT_W-1:0]  outstanding,
   output logic              all_matched
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pkt_conserve_mon: DEPTH must be at least 2");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("pkt_conserve_mon: ADDR_W must be at least 1");
   end
   if (TAG_W != 32) begin : g_bad_tag
      $error("pkt_conserve_mon: byte bus is four bytes wide");
   end

   logic             rd_hit;
   logic             wr_hit;
   tag_t             in_tag;
   tag_t             out_tag;
   logic             ret_hit;
   logic             ins_ok;
   logic             ins_blocked;
   logic [DEPTH-1:0] entry_valid;
   logic [CNT_W-1:0] cnt_q;

   assign rd_hit  = rd_done  && (rd_addr == IO_ADDR);
   assign wr_hit  = wr_issue && (wr_addr == IO_ADDR);
   assign in_tag  = pcm_tag_of(rd_bytes);
   assign out_tag = pcm_tag_of(wr_bytes);

   pcm_tag_table #(.DEPTH(DEPTH)) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .ins_en      (rd_hit),
      .ins_tag     (in_tag),
      .ret_en      (wr_hit),
      .ret_tag     (out_tag),
      .ret_hit     (ret_hit),
      .ins_ok      (ins_ok),
      .ins_blocked (ins_blocked),
      .valid_vec   (entry_valid)
   );

   pcm_overrun_watch u_overrun (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq     (port_irq),
      .rd_hit  (rd_hit),
      .overrun (err_overrun)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q          <= '0;
         err_unexpected <= 1'b0;
         err_overflow   <= 1'b0;
         err_lost       <= 1'b0;
         all_matched    <= 1'b0;
      end else begin
         cnt_q          <= cnt_q + CNT_W'(ins_ok) - CNT_W'(ret_hit);
         err_unexpected <= wr_hit && !ret_hit;
         err_overflow   <= ins_blocked;
         err_lost       <= test_end && (cnt_q != '0);
         if (test_end) begin
            all_matched <= (cnt_q == '0);
         end
      end
   end

   assign outstanding = cnt_q;

endmodule

// File: rtl/pcm_checker.sv
module pcm_checker #(
   parameter int                DEPTH   = 8,
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] IO_ADDR = 16'h0F00,
   parameter int                CNT_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_done,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              wr_issue,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              port_irq,
   input logic              test_end,
   input logic              err_unexpected,
   input logic              err_overflow,
   input logic              err_overrun,
   input logic              err_lost,
   input logic [CNT_W-1:0]  outstanding,
   input logic              all_matched,
   input logic [DEPTH-1:0]  entry_valid
);

   logic rd_on_port;
   logic wr_on_port;
   assign rd_on_port = rd_done  && (rd_addr == IO_ADDR);
   assign wr_on_port = wr_issue && (wr_addr == IO_ADDR);

   AST_IGNORE_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_on_port && !wr_on_port) |=> ($stable(outstanding) && !err_unexpected && !err_overflow)); // R1

   AST_CNT_TRACKS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding == CNT_W'($countones(entry_valid))); // R3

   AST_UNEXP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_on_port && outstanding == '0) |=> err_unexpected); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CNT_W'(DEPTH)); // R6

   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on_port && !wr_issue && outstanding == CNT_W'(DEPTH)) |=> (err_overflow && outstanding == CNT_W'(DEPTH))); // R6

   AST_OVERRUN_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun |-> $past(port_irq)); // R8

   AST_LOST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (test_end && outstanding != '0) |=> (err_lost && !all_matched)); // R9

endmodule

bind pkt_conserve_mon pcm_checker #(
   .DEPTH   (DEPTH),
   .ADDR_W  (ADDR_W),
   .IO_ADDR (IO_ADDR),
   .CNT_W   (CNT_W)
) u_pcm_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .rd_done        (rd_done),
   .rd_addr        (rd_addr),
   .wr_issue       (wr_issue),
   .wr_addr        (wr_addr),
   .port_irq       (port_irq),
   .test_end       (test_end),
   .err_unexpected (err_unexpected),
   .err_overflow   (err_overflow),
   .err_overrun    (err_overrun),
   .err_lost       (err_lost),
   .outstanding    (outstanding),
   .all_matched    (all_matched),
   .entry_valid    (entry_valid)
);

// File: tb/test_pkt_conserve_mon.sv
module test_pkt_conserve_mon;

   localparam int          CLK_PERIOD = 10;
   localparam int          DEPTH      = 8;
   localparam int          ADDR_W     = 16;
   localparam logic [15:0] PORT       = 16'h0F00;
   localparam logic [15:0] ELSE       = 16'h0F04;
   localparam int          CNT_W      = $clog2(DEPTH + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rd_done = 1'b0;
   logic [15:0]      rd_addr = '0;
   logic [31:0]      rd_bytes = '0;
   logic             wr_issue = 1'b0;
   logic [15:0]      wr_addr = '0;
   logic [31:0]      wr_bytes = '0;
   logic             port_irq = 1'b0;
   logic             test_end = 1'b0;
   logic             err_unexpected, err_overflow, err_overrun, err_lost, all_matched;
   logic [CNT_W-1:0] outstanding;

   int tests = 0;
   int fails = 0;

   logic [31:0] mdl[$];
   bit          mdl_unread = 1'b0;
   bit          mdl_am     = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pkt_conserve_mon #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IO_ADDR(PORT)) i_pkt_conserve_mon (
      .clk(clk), .rst_n(rst_n),
      .rd_done(rd_done), .rd_addr(rd_addr), .rd_bytes(rd_bytes),
      .wr_issue(wr_issue), .wr_addr(wr_addr), .wr_bytes(wr_bytes),
      .port_irq(port_irq), .test_end(test_end),
      .err_unexpected(err_unexpected), .err_overflow(err_overflow),
      .err_overrun(err_overrun), .err_lost(err_lost),
      .outstanding(outstanding), .all_matched(all_matched)
   );

   function automatic logic [31:0] tag_of(input logic [7:0] b0, b1, b2, b3);
      return {24'h0, b0} + ({24'h0, b1} << 8) + ({24'h0, b2} << 16) + ({24'h0, b3} << 24);
   endfunction

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act unexp/ovf/ovr/lost/am/cnt=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // One cycle of stimulus, compared one edge later against the reference model.
   task automatic step(input bit iv, input logic [15:0] ia, input logic [31:0] id,
                       input bit ov, input logic [15:0] oa, input logic [31:0] od,
                       input bit irq, input bit te, input string req);
      bit e_unx, e_ovf, e_ovr, e_lost, ih, oh, found;
      int pre;
      @(negedge clk);
      rd_done = iv; rd_addr = ia; rd_bytes = id;
      wr_issue = ov; wr_addr = oa; wr_bytes = od;
      port_irq = irq; test_end = te;
      ih = iv && (ia == PORT);
      oh = ov && (oa == PORT);
      pre = mdl.size();
      e_unx = 1'b0; e_ovf = 1'b0;
      if (oh) begin
         found = 1'b0;
         for (int k = 0; k < mdl.size(); k++) begin
            if (!found && mdl[k] == od) begin
               mdl.delete(k);
               found = 1'b1;
            end
         end
         e_unx = !found;
      end
      if (ih) begin
         if (mdl.size() < DEPTH) mdl.push_back(id);
         else e_ovf = 1'b1;
      end
      e_ovr = irq && mdl_unread && !ih;
      if (irq) mdl_unread = 1'b1;
      else if (ih) mdl_unread = 1'b0;
      e_lost = te && (pre != 0);
      if (te) mdl_am = (pre == 0);
      @(posedge clk);
      #1;
      check(req, {err_unexpected, err_overflow, err_overrun, err_lost, all_matched, outstanding},
                 {e_unx, e_ovf, e_ovr, e_lost, mdl_am, 4'(mdl.size())});
   endtask

   task automatic idle(input string req);
      step(0, PORT, 0, 0, PORT, 0, 0, 0, req);
   endtask

   task automatic drain(input string req);
      while (mdl.size() != 0) step(0, PORT, 0, 1, PORT, mdl[0], 0, 0, req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      tests++;
      fails++;
      $display("FAIL watchdog: act running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] t;
      int r;
      r = $urandom(32'd2024);
      repeat (3) @(posedge clk);
      #1;
      check("R10", {err_unexpected, err_overflow, err_overrun, err_lost, all_matched, outstanding}, 9'b0);
      @(negedge clk);
      rst_n = 1'b1;
      idle("R10");

      // R1: traffic on another address is invisible
      step(1, ELSE, 32'h1234, 0, PORT, 0, 0, 0, "R1");
      step(0, PORT, 0, 1, ELSE, 32'h9999, 0, 0, "R1");

      // R2 / R3: little-endian tag, stored
      t = tag_of(8'h11, 8'h22, 8'h33, 8'h44);
      step(1, PORT, t, 0, PORT, 0, 0, 0, "R3");
      step(0, PORT, 0, 1, PORT, tag_of(8'h44, 8'h33, 8'h22, 8'h11), 0, 0, "R2");
      step(0, PORT, 0, 1, PORT, 32'h44332211, 0, 0, "R2");

      // R4 out of order, R5 unexpected
      step(1, PORT, 32'hA, 0, PORT, 0, 0, 0, "R4");
      step(1, PORT, 32'hB, 0, PORT, 0, 0, 0, "R4");
      step(0, PORT, 0, 1, PORT, 32'hB, 0, 0, "R4");
      step(0, PORT, 0, 1, PORT, 32'hA, 0, 0, "R4");
      step(0, PORT, 0, 1, PORT, 32'hA, 0, 0, "R5");

      // R7 duplicates
      step(1, PORT, 32'h77, 0, PORT, 0, 0, 0, "R7");
      step(1, PORT, 32'h77, 0, PORT, 0, 0, 0, "R7");
      step(0, PORT, 0, 1, PORT, 32'h77, 0, 0, "R7");
      step(0, PORT, 0, 1, PORT, 32'h77, 0, 0, "R7");
      step(0, PORT, 0, 1, PORT, 32'h77, 0, 0, "R7");

      // R6 full table
      for (int k = 0; k < DEPTH; k++) step(1, PORT, 32'h100 + k, 0, PORT, 0, 0, 0, "R6");
      step(1, PORT, 32'h200, 0, PORT, 0, 0, 0, "R6");
      step(0, PORT, 0, 1, PORT, 32'h200, 0, 0, "R6");
      // R11: retire frees a slot for the same-cycle insert
      step(1, PORT, 32'h300, 1, PORT, 32'h103, 0, 0, "R11");
      // R9: end with entries left
      step(0, PORT, 0, 0, PORT, 0, 0, 1, "R9");
      idle("R9");
      drain("R9");
      step(0, PORT, 0, 0, PORT, 0, 0, 1, "R9");
      idle("R9");
      // R11: write cannot match the same-cycle read
      step(1, PORT, 32'h55, 1, PORT, 32'h55, 0, 0, "R11");
      drain("R11");

      // R8 overrun rules
      step(0, PORT, 0, 0, PORT, 0, 1, 0, "R8");
      step(0, PORT, 0, 0, PORT, 0, 1, 0, "R8");
      step(1, PORT, 32'h66, 0, PORT, 0, 1, 0, "R8");
      step(1, PORT, 32'h67, 0, PORT, 0, 0, 0, "R8");
      step(0, PORT, 0, 0, PORT, 0, 1, 0, "R8");
      step(1, ELSE, 32'h68, 0, PORT, 0, 0, 0, "R8");
      step(0, PORT, 0, 0, PORT, 0, 1, 0, "R8");
      drain("R8");

      // mixed random traffic over a small tag set
      for (int n = 0; n < 400; n++) begin
         bit iv, ov, irq, te;
         iv  = ($urandom % 3) == 0;
         ov  = ($urandom % 3) == 0;
         irq = ($urandom % 4) == 0;
         te  = ($urandom % 40) == 0;
         step(iv, (($urandom % 6) == 0) ? ELSE : PORT, 32'hC0DE0000 + ($urandom % 6),
              ov, (($urandom % 6) == 0) ? ELSE : PORT, 32'hC0DE0000 + ($urandom % 6),
              irq, te, "R11");
      end
      drain("R4");
      step(0, PORT, 0, 0, PORT, 0, 0, 1, "R9");
      idle("R9");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule